// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block models the management register file of an Ethernet transceiver as seen from a station manager. It holds thirty-two 16-bit registers selected by a register number, with a single-cycle write strobe and a combinational read port. A separate serial-management framing block drives the strobe, the register number and the write data, and it returns the read data over the wire.

Most registers are plain storage that comes up with fixed identity and control values. Three registers are computed at read time rather than stored. The status word is built from a link-up input. The link-partner ability word always echoes the locally advertised speed and duplex modes, so the modelled partner agrees with whatever best mode is offered. The diagnostic word reports the resolved speed and duplex from those same advertisement bits. The resolved duplex bit is also brought out on its own pin so that a MAC can check its own duplex setting against it.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After synchronous reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 (advertisement) reads 0x01E1, and every other stored register reads 0x0000.
- R2: A read of register 1 returns 0x0000 while `link_up` is low. While `link_up` is high it returns 0x782C: bits 14, 13, 12 and 11 are the ability bits, bit 5 is negotiation complete, bit 3 is negotiation able and bit 2 is link.
- R3: A read of register 5 returns bit 14 set, bit 0 set, bits 8:5 equal to register 4 bits 8:5, and all other bits clear. This holds whatever the link state.
- R4: A read of register 18 returns 0x0000 while `link_up` is low. Otherwise it returns bit 10 set when register 4 bit 7 (100 half) or bit 8 (100 full) is set, and bit 11 set when register 4 bit 6 (10 full) or bit 8 (100 full) is set. All other bits are clear.
- R5: For every register other than 1, 5 and 18, a read returns the last value written, or the reset value if the register has not been written.
- R6: A write to register 1, 5 or 18 does not change what that register reads back.
- R7: Only the low 5 bits of `addr` select a register. Addresses that differ only above bit 4 reach the same register for both reads and writes.
- R8: A write to register 4 is seen in the register 5 and register 18 read values in the cycle after the write strobe.
- R9: `duplex_full` always equals bit 11 of the register 18 read value, whatever register `addr` selects.
- R10: A change of `link_up` shows up on the register 1 and register 18 read values, and on `duplex_full`, in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Line link state; high means link established |
| wr_en | input | 1 | Write strobe; stores `wr_data` at the selected register on the clock edge |
| addr | input | ADDR_IN_W (8) | Register number; only the low 5 bits are decoded |
| wr_data | input | 16 | Data to store |
| rd_data | output | 16 | Combinational read value of the selected register |
| duplex_full | output | 1 | Resolved full-duplex indication for the MAC |

## Verification
The assertions assume that `addr`, `wr_en` and `wr_data` only change between clock edges and are stable at the sampling edge. The bench meets this by driving every input on the falling edge. The store-and-readback property also assumes the framing block presents the same register number again in the cycle after a write. The bench holds `addr` on a write and reads the same address at the next falling edge. Random addresses use the full 8-bit width, so aliases above bit 4 are exercised. Every read also compares the computed registers against a model that tracks register 4 and the link level.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_W    = 16;
    localparam int NUM_REGS = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [IDX_W-1:0] IDX_CTRL    = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_STATUS  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_ID_HI   = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_ID_LO   = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_ADV     = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_PARTNER = IDX_W'(5);
    localparam logic [IDX_W-1:0] IDX_DIAG    = IDX_W'(18);

    // advertisement field position inside register 4
    localparam int ADV_LSB = 5;
    localparam int ADV_MSB = 8;

    // diagnostic word bit positions
    localparam int DIAG_SPEED_BIT  = 10;
    localparam int DIAG_DUPLEX_BIT = 11;

    localparam logic [REG_W-1:0] RST_CTRL  = 16'h3100;
    localparam logic [REG_W-1:0] RST_ID_HI = 16'h0300;
    localparam logic [REG_W-1:0] RST_ID_LO = 16'hE400;
    localparam logic [REG_W-1:0] RST_ADV   = 16'h01E1;

    typedef struct packed {
        logic full_100;
        logic half_100;
        logic full_10;
        logic half_10;
    } adv_modes_t;

    typedef enum logic [1:0] {
        SRC_STORED,
        SRC_STATUS,
        SRC_PARTNER,
        SRC_DIAG
    } rd_src_e;

    function automatic logic [REG_W-1:0] reset_word(input int idx);
        logic [REG_W-1:0] w;
        case (idx)
            int'(IDX_CTRL):  w = RST_CTRL;
            int'(IDX_ID_HI): w = RST_ID_HI;
            int'(IDX_ID_LO): w = RST_ID_LO;
            int'(IDX_ADV):   w = RST_ADV;
            default:         w = '0;
        endcase
        return w;
    endfunction

    function automatic adv_modes_t adv_decode(input logic [REG_W-1:0] adv_reg);
        return adv_modes_t'(adv_reg[ADV_MSB:ADV_LSB]);
    endfunction

    function automatic rd_src_e classify(input logic [IDX_W-1:0] idx);
        rd_src_e s;
        case (idx)
            IDX_STATUS:  s = SRC_STATUS;
            IDX_PARTNER: s = SRC_PARTNER;
            IDX_DIAG:    s = SRC_DIAG;
            default:     s = SRC_STORED;
        endcase
        return s;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic link);
        logic [REG_W-1:0] w;
        w = '0;
        if (link) begin
            w[14] = 1'b1;   // 100 full able
            w[13] = 1'b1;   // 100 half able
            w[12] = 1'b1;   // 10 full able
            w[11] = 1'b1;   // 10 half able
            w[5]  = 1'b1;   // negotiation done
            w[3]  = 1'b1;   // negotiation able
            w[2]  = 1'b1;   // link
        end
        return w;
    endfunction

    function automatic logic [REG_W-1:0] partner_word(input logic [REG_W-1:0] adv_reg);
        logic [REG_W-1:0] w;
        w = '0;
        w[14] = 1'b1;
        w[ADV_MSB:ADV_LSB] = adv_reg[ADV_MSB:ADV_LSB];
        w[0] = 1'b1;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] diag_word(input logic link, input adv_modes_t m);
        logic [REG_W-1:0] w;
        w = '0;
        if (link) begin
            w[DIAG_SPEED_BIT]  = m.full_100 | m.half_100;
            w[DIAG_DUPLEX_BIT] = m.full_100 | m.full_10;
        end
        return w;
    endfunction

endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
    import phy_mgmt_pkg::*;
#(
    parameter int NUM = NUM_REGS,
    parameter int W   = REG_W,
    parameter int IW  = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  regs [NUM]
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM; gi++) begin : g_reg
            localparam logic [IW-1:0] MY_IDX = IW'(gi);
            localparam logic [W-1:0]  MY_RST = W'(reset_word(gi));
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[gi] <= MY_RST;
                end else if (wr_en && (wr_idx == MY_IDX)) begin
                    regs[gi] <= wr_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
    import phy_mgmt_pkg::*;
#(
    parameter int NUM = NUM_REGS,
    parameter int W   = REG_W,
    parameter int IW  = IDX_W
) (
    input  logic          link_up,
    input  logic [IW-1:0] rd_idx,
    input  logic [W-1:0]  regs [NUM],
    output logic [W-1:0]  rd_data,
    output logic          duplex_full
);

    adv_modes_t       modes;
    rd_src_e          src;
    logic [W-1:0]     diag_val;

    always_comb begin
        modes    = adv_decode(regs[IDX_ADV]);
        src      = classify(rd_idx);
        diag_val = diag_word(link_up, modes);
        case (src)
            SRC_STATUS:  rd_data = status_word(link_up);
            SRC_PARTNER: rd_data = partner_word(regs[IDX_ADV]);
            SRC_DIAG:    rd_data = diag_val;
            default:     rd_data = regs[rd_idx];
        endcase
        duplex_full = diag_val[DIAG_DUPLEX_BIT];
    end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_IN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_up,
    input  logic                 wr_en,
    input  logic [ADDR_IN_W-1:0] addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 duplex_full
);

    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] regs [NUM_REGS];

    assign idx = addr[IDX_W-1:0];

    generate
        if (ADDR_IN_W > IDX_W) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr[ADDR_IN_W-1:IDX_W];
        end
    endgenerate

    phy_reg_store #(
        .NUM (NUM_REGS),
        .W   (REG_W),
        .IW  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .regs    (regs)
    );

    phy_read_mux #(
        .NUM (NUM_REGS),
        .W   (REG_W),
        .IW  (IDX_W)
    ) u_rd (
        .link_up     (link_up),
        .rd_idx      (idx),
        .regs        (regs),
        .rd_data     (rd_data),
        .duplex_full (duplex_full)
    );

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
    parameter int ADDR_IN_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 link_up,
    input logic                 wr_en,
    input logic [ADDR_IN_W-1:0] addr,
    input logic [15:0]          wr_data,
    input logic [15:0]          rd_data,
    input logic                 duplex_full
);

    logic [4:0] sel;
    logic       plain_sel;
    assign sel       = addr[4:0];
    assign plain_sel = (sel != 5'd1) && (sel != 5'd5) && (sel != 5'd18);

    AST_RESET_ADV: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && sel == 5'd4) |-> rd_data == 16'h01E1); // R1

    AST_STATUS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!link_up && sel == 5'd1) |-> rd_data == 16'h0000); // R2

    AST_PARTNER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (sel == 5'd5) |-> (rd_data[14] && rd_data[0] && rd_data[15] == 1'b0)); // R3

    AST_DIAG_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!link_up && sel == 5'd18) |-> (rd_data == 16'h0000 && !duplex_full)); // R4

    AST_STORE_BACK: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && plain_sel && $stable(addr)) |-> rd_data == $past(wr_data)); // R5

    AST_ADV_TRACK: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && $past(sel) == 5'd4 && sel == 5'd5)
            |-> rd_data[8:5] == $past(wr_data[8:5])); // R8

    AST_DUPLEX_PIN: assert property (@(posedge clk) disable iff (rst)
        (sel == 5'd18) |-> duplex_full == rd_data[11]); // R9

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.ADDR_IN_W(ADDR_IN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_up     (link_up),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .duplex_full (duplex_full)
);

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        duplex_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model [32];
    logic        m_link = 1'b1;

    always #4 clk = ~clk;

    phy_mgmt_regs #(.ADDR_IN_W(8)) uut (
        .clk(clk), .rst(rst), .link_up(link_up), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .duplex_full(duplex_full)
    );

    function automatic logic [15:0] exp_diag();
        logic [15:0] w = 16'h0;
        if (m_link) begin
            w[10] = model[4][7] | model[4][8];
            w[11] = model[4][6] | model[4][8];
        end
        return w;
    endfunction

    function automatic logic [15:0] exp_read(input logic [4:0] n);
        case (n)
            5'd1:    return m_link ? 16'h782C : 16'h0000;
            5'd5:    return 16'h4001 | (model[4] & 16'h01E0);
            5'd18:   return exp_diag();
            default: return model[n];
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) model[i] = 16'h0000;
        model[0] = 16'h3100;
        model[2] = 16'h0300;
        model[3] = 16'hE400;
        model[4] = 16'h01E1;
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        model[a[4:0]] = d;
    endtask

    task automatic read_chk(input logic [7:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data, exp_read(a[4:0]), tag);
        check({15'h0, duplex_full}, {15'h0, exp_diag()[11]}, "R9 duplex pin");
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v; m_link = v;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values of all registers
        for (int i = 0; i < 32; i++) read_chk(8'(i), "R1 reset value");

        // R2 and R10 status with link toggling, no clock between change and check
        set_link(1'b0);
        #1 addr = 8'd1; #1 check(rd_data, 16'h0000, "R2 status link down");
        link_up = 1'b1; m_link = 1'b1;
        #1 check(rd_data, 16'h782C, "R10 status follows link immediately");
        addr = 8'd18; link_up = 1'b0; m_link = 1'b0;
        #1 check(rd_data, 16'h0000, "R4 diag link down");
        check({15'h0, duplex_full}, 16'h0, "R10 duplex pin drops with link");
        set_link(1'b1);

        // R4 and R8: every advertisement combination
        for (int c = 0; c < 16; c++) begin
            write_reg(8'd4, 16'h0001 | 16'(c << 5));
            read_chk(8'd18, "R8 R4 diag after adv write");
            read_chk(8'd5, "R8 R3 partner after adv write");
        end

        // R3 partner ignores link
        set_link(1'b0);
        read_chk(8'd5, "R3 partner with link down");
        set_link(1'b1);

        // R6 writes to computed registers have no visible effect
        write_reg(8'd1, 16'h0000);
        @(negedge clk); addr = 8'd1; #1 check(rd_data, 16'h782C, "R6 status write ignored");
        write_reg(8'd5, 16'hFFFF);
        @(negedge clk); addr = 8'd5; #1 check(rd_data, exp_read(5'd5), "R6 partner write ignored");
        write_reg(8'd18, 16'hFFFF);
        @(negedge clk); addr = 8'd18; #1 check(rd_data, exp_diag(), "R6 diag write ignored");

        // R7 aliasing above bit 4
        write_reg(8'hE7, 16'hA5C3);
        read_chk(8'h07, "R7 alias read low");
        read_chk(8'h27, "R7 alias read other");
        write_reg(8'h24, 16'h0100);
        read_chk(8'hC4, "R7 alias adv");
        read_chk(8'h12, "R7 R9 diag via alias");

        // R5 plain storage
        write_reg(8'd0, 16'h1234);
        read_chk(8'd0, "R5 store reg0");
        write_reg(8'd31, 16'hBEEF);
        read_chk(8'd31, "R5 store reg31");

        // random mix
        void'($urandom(32'h1F2E3D4C));
        for (int k = 0; k < 600; k++) begin
            logic [7:0] ra;
            ra = 8'($urandom);
            case ($urandom % 8)
                0, 1, 2: write_reg(ra, 16'($urandom));
                3:       set_link(1'($urandom));
                default: read_chk(ra, "R5 random read");
            endcase
        end

        // reset again mid-run: R1
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        model_reset();
        set_link(1'b1);
        read_chk(8'd4, "R1 adv after second reset");
        read_chk(8'd0, "R1 ctrl after second reset");
        read_chk(8'd31, "R1 cleared after second reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule